// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that runs a list of transfer descriptors held in memory. Each descriptor is four 32-bit words, read in this order: a command word, a source address, a target address and a count word. The channel moves the requested number of transfer units from source to target over a request/ready memory port. After each descriptor it either jumps to the next descriptor in the list or, at the end of the list, reports completion and, when asked to, raises an interrupt request.

Software writes the address of the first descriptor into the channel, sets the enable bit in the status register and pulses a doorbell input. The count word carries both the unit count (low 24 bits) and the position of the next descriptor (top 8 bits, in 16-byte steps within the 4 KiB page of the current descriptor). Transfers either run freely (memory-to-memory, request type 0x08) or pace one unit per peripheral request. The live unit count can be read back at any time to report how much work remains.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status register reads 0, the live count reads 0, `irq` is low and `mem_req` is low.
- R2: A started channel reads the descriptor with four word reads (size code 2) at the descriptor address plus 0, 4, 8 and 12, taken as command, source, target and count word; a request keeps its address and direction until `mem_ready` is seen.
- R3: Command bits 10:8 select the unit: 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes, 3 = 16, 4 = 32, 5 = 64, 6 = 128 bytes. Units of 4 bytes or more move as 4-byte beats; 1- and 2-byte units move as one beat of that size, data right-aligned on the data buses, `mem_size` giving log2 of the beat bytes.
- R4: Command bit 23 makes the source address advance by the beat size after each beat and bit 22 does the same for the target address; a clear bit keeps that address fixed.
- R5: Command bit 0 set (linked) makes the channel fetch the next descriptor at the current descriptor address with bits 11:0 replaced by count-word bits 31:24 times 16; the descriptor address register then reads that new address.
- R6: Only a descriptor with bit 0 clear ends the list: then status bit 3 (done) is set, and `irq` rises if command bit 1 is set. A linked descriptor sets neither, whatever its bit 1.
- R7: The live count (register 3) is loaded from count-word bits 23:0, drops by one as each unit's last beat is accepted, and can be written and read by software.
- R8: A descriptor with a unit count of 0 completes with no data traffic.
- R9: A source or target address not aligned to the unit size sets status bits 4 (address error) and 2 (halt), raises `irq`, and stops the channel before any data traffic.
- R10: Unit-size code 7 is treated like a misaligned address (status bits 4 and 2, `irq`, no data traffic).
- R11: Writing the status register with bit 0 clear stops the channel at once; any status write clears `irq` and keeps a flag only where the written bit is 1. A beat accepted in the stopping cycle is not counted.
- R12: Request type 0x08 (register 2) runs without peripheral requests; any other type starts each unit only while `periph_req` is high.
- R13: A doorbell pulse is remembered; the descriptor fetch starts only once status bit 0 (enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 status, 1 descriptor address, 2 request type, 3 live count, 4 source, 5 target |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_addr` |
| kick | input | 1 | Doorbell pulse that asks for a descriptor fetch |
| periph_req | input | 1 | Peripheral request, paces units outside auto mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | log2 of beat bytes |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, right-aligned, valid with `mem_ready` |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a software stop landing in the same cycle that the memory accepts a data write, where the stop must win over the count update and the address advance. The bench watches the memory port between edges, and in the cycle of the third accepted data write of a six-unit copy it drives a status write of zero. It then judges the live count (4, not 3), the target bytes (third beat written, fourth not), the cleared status and `irq`, and the absence of further requests.

// File: rtl/dcc_pkg.sv
// Shared encodings for the linked-descriptor DMA channel.
// Assumes one 32-bit data path and word-indexed software registers.
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_NEXT
    } eng_state_t;

    // software register indices
    localparam logic [2:0] RA_STAT = 3'd0;
    localparam logic [2:0] RA_DESC = 3'd1;
    localparam logic [2:0] RA_REQ  = 3'd2;
    localparam logic [2:0] RA_CNT  = 3'd3;
    localparam logic [2:0] RA_SRC  = 3'd4;
    localparam logic [2:0] RA_TGT  = 3'd5;

    // status bit positions
    localparam int SB_EN   = 0;
    localparam int SB_HALT = 2;
    localparam int SB_DONE = 3;
    localparam int SB_AERR = 4;

    // command bit positions
    localparam int CB_LINK   = 0;
    localparam int CB_TIE    = 1;
    localparam int CB_USZ_LO = 8;
    localparam int CB_TINC   = 22;
    localparam int CB_SINC   = 23;

    localparam int          REQ_W    = 6;
    localparam logic [5:0]  REQ_AUTO = 6'h08;

endpackage

// File: rtl/dcc_unit_decode.sv
// Unit-size decoder: turns the 3-bit unit code into log2 of the unit
// bytes, log2 of the beat bytes and the number of beats per unit.
// Assumes a 32-bit data path, so no beat is wider than 4 bytes.
module dcc_unit_decode (
    input  logic [2:0] code,
    output logic       legal,
    output logic [2:0] unit_log2,
    output logic [1:0] beat_log2,
    output logic [4:0] beats_m1
);
    logic [5:0] nbeats;

    // code to unit size
    always_comb begin
        legal = 1'b1;
        case (code)
            3'd0:    unit_log2 = 3'd2;
            3'd1:    unit_log2 = 3'd0;
            3'd2:    unit_log2 = 3'd1;
            3'd3:    unit_log2 = 3'd4;
            3'd4:    unit_log2 = 3'd5;
            3'd5:    unit_log2 = 3'd6;
            3'd6:    unit_log2 = 3'd7;
            default: begin
                unit_log2 = 3'd2;
                legal     = 1'b0;
            end
        endcase
    end

    // beat size and beats per unit
    always_comb begin
        if (unit_log2 > 3'd2) begin
            beat_log2 = 2'd2;
            nbeats    = 6'd1 << (unit_log2 - 3'd2);
        end else begin
            beat_log2 = unit_log2[1:0];
            nbeats    = 6'd1;
        end
        beats_m1 = 5'(nbeats - 6'd1);
    end
endmodule

// File: rtl/dcc_ctrl_regs.sv
// Control registers: enable, status flags, interrupt, request type and
// the remembered doorbell. Produces the launch and stop pulses.
// Assumes engine events never coincide with their own stop (engine gates them).
module dcc_ctrl_regs
    import dcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_we,
    input  logic [4:0]       stat_wd,
    input  logic             req_we,
    input  logic [REQ_W-1:0] req_wd,
    input  logic             kick,
    input  logic             busy,
    input  logic             ev_done,
    input  logic             ev_done_irq,
    input  logic             ev_err,
    output logic             en_q,
    output logic             halt_q,
    output logic             done_q,
    output logic             aerr_q,
    output logic             irq_q,
    output logic [REQ_W-1:0] req_q,
    output logic             auto_mode,
    output logic             launch,
    output logic             stop
);
    logic pend_q;

    // stop request and launch condition
    always_comb begin
        stop      = stat_we && !stat_wd[SB_EN];
        launch    = pend_q && en_q && !busy && !stop;
        auto_mode = (req_q == REQ_AUTO);
    end

    // flag, enable, interrupt and doorbell state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            halt_q <= 1'b0;
            done_q <= 1'b0;
            aerr_q <= 1'b0;
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
            req_q  <= '0;
        end else begin
            if (stat_we) begin
                en_q   <= stat_wd[SB_EN];
                halt_q <= halt_q && stat_wd[SB_HALT];
                done_q <= done_q && stat_wd[SB_DONE];
                aerr_q <= aerr_q && stat_wd[SB_AERR];
                irq_q  <= 1'b0;
            end
            if (req_we) begin
                req_q <= req_wd;
            end
            if (ev_err) begin
                halt_q <= 1'b1;
                aerr_q <= 1'b1;
                irq_q  <= 1'b1;
            end
            if (ev_done) begin
                done_q <= 1'b1;
            end
            if (ev_done_irq) begin
                irq_q <= 1'b1;
            end
            if (stop) begin
                pend_q <= 1'b0;
            end else if (kick) begin
                pend_q <= 1'b1;
            end else if (launch) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dcc_engine.sv
// Channel engine: fetches a four-word descriptor, checks it, moves the
// units beat by beat (read then write) and follows links.
// Assumes the memory answers one request per handshake with data valid
// alongside mem_ready, and a descriptor list that stays in one page.
module dcc_engine
    import dcc_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          stop,
    input  logic          auto_mode,
    input  logic          periph_req,
    input  logic          sw_desc_we,
    input  logic          sw_cnt_we,
    input  logic [31:0]   sw_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          ev_done,
    output logic          ev_done_irq,
    output logic          ev_err,
    output logic [AW-1:0] desc_q,
    output logic [CW-1:0] cnt_q,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] tgt_q
);
    localparam int OFF_W  = 32 - CW;
    localparam int PAGE_W = OFF_W + 4;

    eng_state_t       st_q;
    logic [1:0]       widx_q;
    logic             link_q;
    logic             tie_q;
    logic             sinc_q;
    logic             tinc_q;
    logic [2:0]       code_q;
    logic [OFF_W-1:0] off_q;
    logic [4:0]       beat_q;
    logic [31:0]      data_q;

    logic             legal;
    logic [2:0]       unit_log2;
    logic [1:0]       beat_log2;
    logic [4:0]       beats_m1;
    logic [AW-1:0]    umask;
    logic [AW-1:0]    step;
    logic             bad_desc;
    logic [AW-1:0]    next_desc;

    dcc_unit_decode u_dec (
        .code      (code_q),
        .legal     (legal),
        .unit_log2 (unit_log2),
        .beat_log2 (beat_log2),
        .beats_m1  (beats_m1)
    );

    // descriptor checks and derived addresses
    always_comb begin
        umask     = (AW'(1) << unit_log2) - AW'(1);
        step      = AW'(1) << beat_log2;
        bad_desc  = !legal || (|((src_q | tgt_q) & umask));
        next_desc = {desc_q[AW-1:PAGE_W], off_q, 4'h0};
    end

    // memory port drive and engine events
    always_comb begin
        busy        = (st_q != ST_IDLE);
        mem_req     = (st_q == ST_FETCH) || (st_q == ST_RD) || (st_q == ST_WR);
        mem_we      = (st_q == ST_WR);
        mem_wdata   = data_q;
        mem_size    = (st_q == ST_FETCH) ? 2'd2 : beat_log2;
        case (st_q)
            ST_RD:   mem_addr = src_q;
            ST_WR:   mem_addr = tgt_q;
            default: mem_addr = desc_q + AW'({widx_q, 2'b00});
        endcase
        ev_err      = (st_q == ST_CHECK) && bad_desc && !stop;
        ev_done     = (st_q == ST_NEXT) && !link_q && !stop;
        ev_done_irq = ev_done && tie_q;
    end

    // sequencing of fetch, check, data beats and links
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            widx_q <= '0;
            link_q <= 1'b0;
            tie_q  <= 1'b0;
            sinc_q <= 1'b0;
            tinc_q <= 1'b0;
            code_q <= '0;
            off_q  <= '0;
            beat_q <= '0;
            data_q <= '0;
            desc_q <= '0;
            cnt_q  <= '0;
            src_q  <= '0;
            tgt_q  <= '0;
        end else begin
            if (sw_desc_we) begin
                desc_q <= sw_wdata[AW-1:0];
            end
            if (sw_cnt_we) begin
                cnt_q <= sw_wdata[CW-1:0];
            end
            if (stop) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (launch) begin
                            st_q   <= ST_FETCH;
                            widx_q <= '0;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_ready) begin
                            case (widx_q)
                                2'd0: begin
                                    link_q <= mem_rdata[CB_LINK];
                                    tie_q  <= mem_rdata[CB_TIE];
                                    code_q <= mem_rdata[CB_USZ_LO +: 3];
                                    tinc_q <= mem_rdata[CB_TINC];
                                    sinc_q <= mem_rdata[CB_SINC];
                                end
                                2'd1: src_q <= mem_rdata[AW-1:0];
                                2'd2: tgt_q <= mem_rdata[AW-1:0];
                                default: begin
                                    cnt_q <= mem_rdata[CW-1:0];
                                    off_q <= mem_rdata[31:CW];
                                end
                            endcase
                            if (widx_q == 2'd3) begin
                                st_q <= ST_CHECK;
                            end
                            widx_q <= widx_q + 2'd1;
                        end
                    end
                    ST_CHECK: begin
                        beat_q <= '0;
                        if (bad_desc) begin
                            st_q <= ST_IDLE;
                        end else if (cnt_q == '0) begin
                            st_q <= ST_NEXT;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (auto_mode || periph_req) begin
                            st_q <= ST_RD;
                        end
                    end
                    ST_RD: begin
                        if (mem_ready) begin
                            data_q <= mem_rdata;
                            st_q   <= ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (mem_ready) begin
                            if (sinc_q) begin
                                src_q <= src_q + step;
                            end
                            if (tinc_q) begin
                                tgt_q <= tgt_q + step;
                            end
                            if (beat_q == beats_m1) begin
                                beat_q <= '0;
                                cnt_q  <= cnt_q - CW'(1);
                                st_q   <= (cnt_q == CW'(1)) ? ST_NEXT : ST_WAIT;
                            end else begin
                                beat_q <= beat_q + 5'd1;
                                st_q   <= ST_RD;
                            end
                        end
                    end
                    ST_NEXT: begin
                        if (link_q) begin
                            desc_q <= next_desc;
                            widx_q <= '0;
                            st_q   <= ST_FETCH;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_chain_chan.sv
// Top of the linked-descriptor DMA channel: register decode and read
// mux around the control registers and the channel engine.
// Assumes software writes the descriptor address and count only while idle.
module dma_chain_chan
    import dcc_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          kick,
    input  logic          periph_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          irq
);
    logic             stat_we, req_we, desc_we, cnt_we;
    logic             en_q, halt_q, done_q, aerr_q, irq_q;
    logic [REQ_W-1:0] req_q;
    logic             auto_mode, launch, stop, busy;
    logic             ev_done, ev_done_irq, ev_err;
    logic [AW-1:0]    desc_q, src_q, tgt_q;
    logic [CW-1:0]    cnt_q;
    logic [31:0]      stat_word;

    // write strobes per register
    always_comb begin
        stat_we = reg_wr && (reg_addr == RA_STAT);
        desc_we = reg_wr && (reg_addr == RA_DESC);
        req_we  = reg_wr && (reg_addr == RA_REQ);
        cnt_we  = reg_wr && (reg_addr == RA_CNT);
    end

    dcc_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_we     (stat_we),
        .stat_wd     (reg_wdata[4:0]),
        .req_we      (req_we),
        .req_wd      (reg_wdata[REQ_W-1:0]),
        .kick        (kick),
        .busy        (busy),
        .ev_done     (ev_done),
        .ev_done_irq (ev_done_irq),
        .ev_err      (ev_err),
        .en_q        (en_q),
        .halt_q      (halt_q),
        .done_q      (done_q),
        .aerr_q      (aerr_q),
        .irq_q       (irq_q),
        .req_q       (req_q),
        .auto_mode   (auto_mode),
        .launch      (launch),
        .stop        (stop)
    );

    dcc_engine #(.AW(AW), .CW(CW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .stop        (stop),
        .auto_mode   (auto_mode),
        .periph_req  (periph_req),
        .sw_desc_we  (desc_we),
        .sw_cnt_we   (cnt_we),
        .sw_wdata    (reg_wdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_size    (mem_size),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .ev_done     (ev_done),
        .ev_done_irq (ev_done_irq),
        .ev_err      (ev_err),
        .desc_q      (desc_q),
        .cnt_q       (cnt_q),
        .src_q       (src_q),
        .tgt_q       (tgt_q)
    );

    // status word assembly
    always_comb begin
        stat_word          = '0;
        stat_word[SB_EN]   = en_q;
        stat_word[SB_HALT] = halt_q;
        stat_word[SB_DONE] = done_q;
        stat_word[SB_AERR] = aerr_q;
        irq                = irq_q;
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_STAT: reg_rdata = stat_word;
            RA_DESC: reg_rdata = 32'(desc_q);
            RA_REQ:  reg_rdata = 32'(req_q);
            RA_CNT:  reg_rdata = 32'(cnt_q);
            RA_SRC:  reg_rdata = 32'(src_q);
            RA_TGT:  reg_rdata = 32'(tgt_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dcc_checker.sv
// Protocol and status checker for the DMA channel, bound to the top.
module dcc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ready,
    input logic        irq,
    input logic [31:0] stat_word
);
    logic stop_wr;
    assign stop_wr = reg_wr && (reg_addr == 3'd0) && !reg_wdata[0];

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !stop_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 3'd0) && (reg_wdata == 32'd0) |=> !irq && !mem_req && (stat_word[4:2] == 3'b000));

    // R9
    aerr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[4]) |-> stat_word[2] && irq);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat_word[3] || stat_word[4]));
endmodule

bind dma_chain_chan dcc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .irq       (irq),
    .stat_word (stat_word)
);

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        kick = 1'b0;
    logic        periph_req = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        irq;

    logic [7:0]  bmem [0:4095];
    logic [7:0]  exp_b [0:255];
    logic        rdy_ok = 1'b1;
    int          stall_cnt = 0;
    int          hs_total = 0;
    int          irq_rise_hs = -1;
    logic        irq_d = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    // vector: [23:21] unit code, [20] source increment, [19] target increment, [15:0] unit count
    localparam logic [23:0] VEC [7] = '{
        24'h180004, 24'h380005, 24'h580003, 24'h780002,
        24'hD80001, 24'h080003, 24'hB00002
    };

    always #2 clk = ~clk;

    dma_chain_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kick(kick),
        .periph_req(periph_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    assign mem_ready = mem_req && rdy_ok;

    // memory model read path, right-aligned beat data
    always_comb begin
        mem_rdata = 32'd0;
        for (int b = 0; b < 4; b++) begin
            if (b < (1 << mem_size)) mem_rdata[8*b +: 8] = bmem[(mem_addr + b) & 32'hfff];
        end
    end

    // memory model write path and handshake counter
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            hs_total <= hs_total + 1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++) begin
                    if (b < (1 << mem_size)) bmem[(mem_addr + b) & 32'hfff] <= mem_wdata[8*b +: 8];
                end
            end
        end
    end

    // ready stall pattern and interrupt rise capture
    always @(negedge clk) begin
        stall_cnt <= stall_cnt + 1;
        rdy_ok    <= (stall_cnt % 3) != 2;
        if (irq && !irq_d) irq_rise_hs = hs_total;
        irq_d = irq;
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired: actual=%0d expected=<150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic put_w(input int a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) bmem[a + b] = w[8*b +: 8];
    endtask

    task automatic put_desc(input int a, input logic [31:0] cmd, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] cw);
        put_w(a, cmd); put_w(a + 4, s); put_w(a + 8, t); put_w(a + 12, cw);
    endtask

    function automatic logic [31:0] mk_cmd(input int code, input bit si, input bit ti, input bit lnk, input bit tie);
        return (32'(si) << 23) | (32'(ti) << 22) | (32'(code) << 8) | (32'(tie) << 1) | 32'(lnk);
    endfunction

    function automatic int unit_bytes(input int code);
        case (code)
            0: return 4;  1: return 1;  2: return 2;  3: return 16;
            4: return 32; 5: return 64; default: return 128;
        endcase
    endfunction

    task automatic clear_dst();
        for (int i = 12'h800; i < 4096; i++) bmem[i] = 8'h00;
        for (int i = 0; i < 256; i++) exp_b[i] = 8'h00;
    endtask

    task automatic wait_end();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(3'd0, s);
            if (s[3] || s[4]) break;
        end
    endtask

    function automatic int dst_mism();
        int m = 0;
        for (int i = 0; i < 256; i++) if (bmem[12'h800 + i] !== exp_b[i]) m++;
        return m;
    endfunction

    task automatic start(input logic [31:0] req_type);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd2, req_type);
        wr_reg(3'd0, 32'h1);
        pulse_kick();
    endtask

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
        for (int i = 0; i < 256; i++) bmem[12'h400 + i] = 8'((i * 7 + 3) ^ (i >> 3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_reg(3'd0, v); chk(v == 0, "R1 status", v, 0);
        rd_reg(3'd3, v); chk(v == 0, "R1 count", v, 0);
        chk(!irq && !mem_req, "R1 irq/mem_req", {30'd0, irq, mem_req}, 0);

        // vector table: single-descriptor copies, R2 R3 R4 R7 R6
        for (int k = 0; k < 7; k++) begin
            int code, cnt, ub, bb, nb;
            bit si, ti;
            code = int'(VEC[k][23:21]); si = VEC[k][20]; ti = VEC[k][19]; cnt = int'(VEC[k][15:0]);
            ub = unit_bytes(code); bb = (ub > 4) ? 4 : ub; nb = cnt * (ub / bb);
            clear_dst();
            for (int j = 0; j < nb; j++)
                for (int b = 0; b < bb; b++)
                    exp_b[(ti ? j * bb : 0) + b] = bmem[12'h400 + (si ? j * bb : 0) + b];
            put_desc(0, mk_cmd(code, si, ti, 1'b0, 1'b1), 32'h400, 32'h800, 32'(cnt));
            start(32'h8);
            wait_end();
            chk(dst_mism() == 0, "R2 R3 R4 target bytes", 32'(dst_mism()), 0);
            rd_reg(3'd3, v); chk(v == 0, "R7 count at end", v, 0);
            rd_reg(3'd0, v); chk(v == 32'h9, "R6 status done", v, 32'h9);
            chk(irq == 1'b1, "R6 irq at end", 32'(irq), 1);
            wr_reg(3'd0, 32'h0);
            chk(irq == 1'b0, "R11 irq cleared", 32'(irq), 0);
        end

        // R5 R6 linked chain of three descriptors
        clear_dst();
        put_desc(12'h000, mk_cmd(0, 1, 1, 1, 1), 32'h400, 32'h800, 32'h04000002);
        put_desc(12'h040, mk_cmd(0, 1, 1, 1, 1), 32'h410, 32'h810, 32'h10000002);
        put_desc(12'h100, mk_cmd(0, 1, 1, 0, 1), 32'h420, 32'h820, 32'h00000002);
        for (int i = 0; i < 8; i++) begin
            exp_b[i] = bmem[12'h400 + i]; exp_b[16 + i] = bmem[12'h410 + i]; exp_b[32 + i] = bmem[12'h420 + i];
        end
        base = hs_total; irq_rise_hs = -1;
        start(32'h8);
        wait_end();
        chk(dst_mism() == 0, "R5 chain target bytes", 32'(dst_mism()), 0);
        chk(irq_rise_hs - base == 24, "R6 irq only after last descriptor", 32'(irq_rise_hs - base), 24);
        rd_reg(3'd1, v); chk(v == 32'h100, "R5 descriptor address followed", v, 32'h100);
        wr_reg(3'd0, 32'h0);

        // R6 end without interrupt enable
        clear_dst();
        put_desc(0, mk_cmd(0, 1, 1, 0, 0), 32'h400, 32'h800, 32'h1);
        start(32'h8); wait_end();
        rd_reg(3'd0, v); chk(v == 32'h9, "R6 done without tie", v, 32'h9);
        chk(irq == 1'b0, "R6 no irq without tie", 32'(irq), 0);
        wr_reg(3'd0, 32'h0);

        // R8 zero count
        clear_dst(); base = hs_total;
        put_desc(0, mk_cmd(0, 1, 1, 0, 1), 32'h400, 32'h800, 32'h0);
        start(32'h8); wait_end();
        rd_reg(3'd0, v); chk(v == 32'h9, "R8 zero count done", v, 32'h9);
        chk(hs_total - base == 4, "R8 only descriptor traffic", 32'(hs_total - base), 4);
        wr_reg(3'd0, 32'h0);

        // R9 misaligned source
        base = hs_total;
        put_desc(0, mk_cmd(0, 1, 1, 0, 1), 32'h402, 32'h800, 32'h2);
        start(32'h8); wait_end();
        rd_reg(3'd0, v); chk(v == 32'h15, "R9 address error status", v, 32'h15);
        chk(irq == 1'b1, "R9 irq", 32'(irq), 1);
        chk(hs_total - base == 4, "R9 no data traffic", 32'(hs_total - base), 4);
        wr_reg(3'd0, 32'h0);

        // R10 unit code 7
        base = hs_total;
        put_desc(0, mk_cmd(7, 1, 1, 0, 1), 32'h400, 32'h800, 32'h2);
        start(32'h8); wait_end();
        rd_reg(3'd0, v); chk(v == 32'h15, "R10 illegal code status", v, 32'h15);
        chk(hs_total - base == 4, "R10 no data traffic", 32'(hs_total - base), 4);
        wr_reg(3'd0, 32'h0);

        // R12 peripheral paced, R7 live count
        clear_dst(); base = hs_total;
        put_desc(0, mk_cmd(0, 1, 1, 0, 1), 32'h400, 32'h800, 32'h3);
        start(32'h0);
        repeat (40) @(negedge clk);
        chk(hs_total - base == 4, "R12 waits for peripheral", 32'(hs_total - base), 4);
        rd_reg(3'd3, v); chk(v == 3, "R7 count loaded", v, 3);
        periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_reg(3'd3, v); chk(v == 2, "R7 R12 one unit per request", v, 2);
        periph_req = 1'b1;
        wait_end();
        periph_req = 1'b0;
        rd_reg(3'd0, v); chk(v == 32'h9, "R12 paced run done", v, 32'h9);
        wr_reg(3'd0, 32'h0);

        // R13 doorbell waits for enable
        base = hs_total;
        put_desc(0, mk_cmd(0, 1, 1, 0, 1), 32'h400, 32'h800, 32'h1);
        wr_reg(3'd1, 32'h0); wr_reg(3'd2, 32'h8);
        pulse_kick();
        repeat (20) @(negedge clk);
        chk(hs_total - base == 0, "R13 no fetch while disabled", 32'(hs_total - base), 0);
        wr_reg(3'd0, 32'h1);
        wait_end();
        rd_reg(3'd0, v); chk(v == 32'h9, "R13 runs after enable", v, 32'h9);
        wr_reg(3'd0, 32'h0);

        // R7 software count write
        wr_reg(3'd3, 32'h123456);
        rd_reg(3'd3, v); chk(v == 32'h123456, "R7 count write", v, 32'h123456);

        // R11 stop in the cycle of the third accepted data write
        begin
            int wseen = 0;
            bit req_seen = 1'b0;
            clear_dst();
            put_desc(0, mk_cmd(0, 1, 1, 0, 1), 32'h400, 32'h800, 32'h6);
            start(32'h8);
            for (int i = 0; i < 500 && wseen < 3; i++) begin
                @(negedge clk); #1;
                if (mem_req && mem_we && mem_ready) begin
                    wseen++;
                    if (wseen == 3) begin
                        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
                    end
                end
            end
            @(negedge clk); reg_wr = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk); if (mem_req) req_seen = 1'b1;
            end
            chk(!req_seen, "R11 no traffic after stop", 32'(req_seen), 0);
            rd_reg(3'd3, v); chk(v == 4, "R11 stopped beat not counted", v, 4);
            rd_reg(3'd0, v); chk(v == 0, "R11 status cleared", v, 0);
            chk(bmem[12'h808] == bmem[12'h408] && bmem[12'h80c] == 8'h00, "R11 third beat written only",
                {bmem[12'h808], bmem[12'h80c]}, {bmem[12'h408], 8'h00});
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule